// File: doc/BRIEF.md
# Deserializer Training Pattern Checker

This block sits behind a receive deserializer and watches the recovered serial bit stream for a periodic training pattern. It raises a lock flag only after the pattern has repeated back to back enough times. A two-bit protocol select chooses which family of patterns is expected. The pattern may begin at any bit rotation. The first complete period the block sees fixes the alignment, and every later bit must repeat the bit exactly one period earlier. A single wrong bit emits a one-cycle error pulse, clears the repetition count and sends the block back to searching.

Bits enter on a valid/ready stream. A bit is consumed on every clock edge where `in_valid` is high. The block never applies back-pressure, so `in_ready` is held high at all times. Cycles with `in_valid` low are idle and change nothing.

All outputs are registered. They reflect a bit one clock after the edge that consumed it.

Top module: `train_lock_detect`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `locked`, `err_pulse` and `rep_count` are 0. `in_ready` is always 1.
- R2: With protocol code 0, the expected period is 20 bits: ten 0s then ten 1s, in arrival order. The period may start at any rotation. `locked` rises on the edge where `rep_count` reaches 256.
- R3: With protocol code 1, either of two 8-bit periods is accepted at any rotation: 00001111 or 10010000, in arrival order. `locked` rises when `rep_count` reaches the parameter `THR_BC`, which defaults to 256.
- R4: With protocol code 2, the 8-bit alternating period 10101010 or 01010101 is accepted, and lock follows `THR_BC`. With protocol code 3, the block never locks.
- R5: `rep_count` becomes 1 on the edge that completes the first full period, and no earlier. After that it rises by exactly 1 for every further period of valid bits, and it saturates at its maximum.
- R6: A constant stream, or any stream that is not a rotation of an accepted period, leaves `rep_count` at 0 and `locked` low.
- R7: While tracking, a bit that differs from the bit received one period earlier does four things on the next edge: it gives a one-cycle `err_pulse`, clears `rep_count` and `locked`, and restarts the search. The new search needs one full period of fresh bits before `rep_count` can become 1 again.
- R8: A cycle with `in_valid` low leaves `rep_count` and `locked` unchanged and produces no `err_pulse`.
- R9: On the clock after `proto_sel` changes, `rep_count` is 0, `locked` is 0 and the search restarts.
- R10: Once set, `locked` stays high while correct periods keep arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Serial bit present this cycle |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_bit | input | 1 | Serial data bit |
| proto_sel | input | 2 | 0: 20-bit period, 1: 8-bit nibble pair, 2: alternating, 3: none |
| locked | output | 1 | Pattern has repeated at least the threshold count |
| rep_count | output | CNT_W | Consecutive complete periods counted |
| err_pulse | output | 1 | One-cycle pulse on a mismatch while tracking |

## Verification
A wrong alignment phase or a stale history bit shows up at the ports as an `err_pulse` within one period of the fault: 20 valid bits in code 0, 8 in the other codes. A miscounted phase counter shows up as a `rep_count` step that arrives early or late relative to the period boundary, and that is visible at the first boundary. A wrong threshold selection moves the edge where `locked` rises away from the 256th period. The tests therefore sample on both sides of each boundary.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    PROTO_LONG   = 2'd0,
    PROTO_NIBBLE = 2'd1,
    PROTO_TOGGLE = 2'd2,
    PROTO_NONE   = 2'd3
  } proto_e;

  localparam int LONG_LEN  = 20;
  localparam int SHORT_LEN = 8;
  localparam int LONG_REPS = 256;

  // Patterns are written first-arriving bit in the MSB.
  localparam logic [LONG_LEN-1:0]  PAT_LONG  = 20'h003FF;
  localparam logic [SHORT_LEN-1:0] PAT_NIB_A = 8'h0F;
  localparam logic [SHORT_LEN-1:0] PAT_NIB_B = 8'h90;
  localparam logic [SHORT_LEN-1:0] PAT_TOG   = 8'hAA;

  function automatic logic [LONG_LEN-1:0] rot_long(logic [LONG_LEN-1:0] v, int n);
    return (v << n) | (v >> (LONG_LEN - n));
  endfunction

  function automatic logic [SHORT_LEN-1:0] rot_short(logic [SHORT_LEN-1:0] v, int n);
    return (v << n) | (v >> (SHORT_LEN - n));
  endfunction

endpackage

// File: rtl/tpc_rot_match.sv
module tpc_rot_match
  import tpc_pkg::*;
(
  input  logic [LONG_LEN-1:0] win,
  input  proto_e              mode,
  output logic                hit
);

  logic [LONG_LEN-1:0]  hit_long;
  logic [SHORT_LEN-1:0] hit_na;
  logic [SHORT_LEN-1:0] hit_nb;

  // One comparator per rotation of each candidate period.
  for (genvar r = 0; r < LONG_LEN; r++) begin : g_long
    assign hit_long[r] = (win == rot_long(PAT_LONG, r));
  end

  for (genvar r = 0; r < SHORT_LEN; r++) begin : g_short
    assign hit_na[r] = (win[SHORT_LEN-1:0] == rot_short(PAT_NIB_A, r));
    assign hit_nb[r] = (win[SHORT_LEN-1:0] == rot_short(PAT_NIB_B, r));
  end

  always_comb begin
    case (mode)
      PROTO_LONG:   hit = |hit_long;
      PROTO_NIBBLE: hit = (|hit_na) | (|hit_nb);
      PROTO_TOGGLE: hit = (win[SHORT_LEN-1:0] == PAT_TOG) ||
                          (win[SHORT_LEN-1:0] == ~PAT_TOG);
      default:      hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/tpc_rep_count.sv
module tpc_rep_count #(
  parameter int CNT_W = 9,
  parameter int PH_W  = 5
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             start,
  input  logic             fail,
  input  logic             adv,
  input  logic [PH_W-1:0]  last_phase,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] rep,
  output logic             locked
);

  localparam logic [CNT_W-1:0] REP_MAX = '1;

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] rep_inc;

  assign rep_inc = (rep == REP_MAX) ? rep : rep + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (clr || fail) begin
      phase  <= '0;
      rep    <= '0;
      locked <= 1'b0;
    end else if (start) begin
      phase  <= '0;
      rep    <= CNT_W'(1);
      locked <= (CNT_W'(1) >= thr);
    end else if (adv) begin
      if (phase == last_phase) begin
        phase  <= '0;
        rep    <= rep_inc;
        locked <= (rep_inc >= thr);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

endmodule

// File: rtl/train_lock_detect.sv
module train_lock_detect
  import tpc_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int THR_BC = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic [1:0]       proto_sel,
  output logic             locked,
  output logic [CNT_W-1:0] rep_count,
  output logic             err_pulse
);

  localparam int              HIST_W    = LONG_LEN;
  localparam int              PH_W      = $clog2(HIST_W + 1);
  localparam logic [CNT_W-1:0] THR_LONG  = CNT_W'(LONG_REPS);
  localparam logic [CNT_W-1:0] THR_SHORT = CNT_W'(THR_BC);

  typedef enum logic {ST_SEARCH, ST_TRACK} state_e;

  state_e            state;
  proto_e            mode_q;
  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] hist_nxt;
  logic [PH_W-1:0]   fill;
  logic [PH_W-1:0]   fill_inc;
  logic [PH_W-1:0]   period;
  logic [CNT_W-1:0]  thr;
  logic              proto_chg;
  logic              take;
  logic              hit;
  logic              exp_bit;
  logic              start;
  logic              fail;
  logic              adv;

  assign in_ready  = 1'b1;
  assign proto_chg = (proto_sel != mode_q);
  assign take      = in_valid && !proto_chg;
  assign hist_nxt  = {hist[HIST_W-2:0], in_bit};
  assign fill_inc  = (fill == PH_W'(HIST_W)) ? fill : fill + PH_W'(1);
  assign period    = (mode_q == PROTO_LONG) ? PH_W'(LONG_LEN) : PH_W'(SHORT_LEN);
  assign thr       = (mode_q == PROTO_LONG) ? THR_LONG : THR_SHORT;
  // Bit received exactly one period earlier.
  assign exp_bit   = (mode_q == PROTO_LONG) ? hist[LONG_LEN-1] : hist[SHORT_LEN-1];

  assign start = take && (state == ST_SEARCH) && hit && (fill_inc >= period);
  assign fail  = take && (state == ST_TRACK) && (in_bit != exp_bit);
  assign adv   = take && (state == ST_TRACK) && (in_bit == exp_bit);

  tpc_rot_match u_match (
    .win  (hist_nxt),
    .mode (mode_q),
    .hit  (hit)
  );

  tpc_rep_count #(.CNT_W(CNT_W), .PH_W(PH_W)) u_count (
    .clk        (clk),
    .clr        (rst || proto_chg),
    .start      (start),
    .fail       (fail),
    .adv        (adv),
    .last_phase (period - PH_W'(1)),
    .thr        (thr),
    .rep        (rep_count),
    .locked     (locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= proto_e'(proto_sel);
      state     <= ST_SEARCH;
      fill      <= '0;
      hist      <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= fail;
      if (proto_chg) begin
        mode_q <= proto_e'(proto_sel);
        state  <= ST_SEARCH;
        fill   <= '0;
      end else if (take) begin
        hist <= hist_nxt;
        if (fail) begin
          fill  <= '0;
          state <= ST_SEARCH;
        end else begin
          fill <= fill_inc;
          if (start) state <= ST_TRACK;
        end
      end
    end
  end

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int CNT_W  = 9,
  parameter int THR_BC = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       proto_sel,
  input logic             locked,
  input logic [CNT_W-1:0] rep_count,
  input logic             err_pulse
);

  localparam logic [CNT_W-1:0] LONG_THR = CNT_W'(256);
  localparam logic [CNT_W-1:0] BC_THR   = CNT_W'(THR_BC);

  assert_err_single_R7: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);

  assert_err_clears_R7: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (!locked && rep_count == '0));

  assert_rep_step_R5: assert property (@(posedge clk) disable iff (rst)
    (rep_count != $past(rep_count)) |->
      (rep_count == $past(rep_count) + CNT_W'(1) || rep_count == '0));

  assert_long_thr_R2: assert property (@(posedge clk) disable iff (rst)
    (locked && proto_sel == 2'd0 && $stable(proto_sel)) |-> (rep_count >= LONG_THR));

  assert_short_thr_R3: assert property (@(posedge clk) disable iff (rst)
    (locked && proto_sel == 2'd1 && $stable(proto_sel)) |-> (rep_count >= BC_THR));

  assert_none_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
    (proto_sel == 2'd3 && $stable(proto_sel)) |-> !locked);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && $stable(proto_sel)) |=>
      ($stable(rep_count) && $stable(locked) && !err_pulse));

  assert_proto_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (proto_sel != $past(proto_sel)) |=> (!locked && rep_count == '0));

endmodule

bind train_lock_detect tpc_checker #(.CNT_W(CNT_W), .THR_BC(THR_BC)) u_chk (.*);

// File: tb/train_lock_detect_tb.sv
`timescale 1ns/1ps
module train_lock_detect_tb;

  localparam int CNT_W = 9;
  localparam int THR   = 256;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_bit = 1'b0;
  logic [1:0]       proto_sel = 2'd0;
  logic             in_ready;
  logic             locked;
  logic [CNT_W-1:0] rep_count;
  logic             err_pulse;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  train_lock_detect #(.CNT_W(CNT_W), .THR_BC(THR)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .proto_sel(proto_sel), .locked(locked),
    .rep_count(rep_count), .err_pulse(err_pulse)
  );

  localparam int NV = 6;
  localparam logic [1:0]  V_PROTO [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2};
  localparam logic [19:0] V_PAT   [NV] = '{20'h003FF, 20'h003FF, 20'h0000F,
                                           20'h00090, 20'h000AA, 20'h00055};
  localparam int          V_PER   [NV] = '{20, 20, 8, 8, 8, 8};
  localparam int          V_OFF   [NV] = '{0, 7, 3, 5, 0, 3};

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic send(logic b);
    in_valid = 1'b1;
    in_bit   = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic do_reset(logic [1:0] p);
    rst = 1'b1; proto_sel = p; in_valid = 1'b0;
    idle(2);
    rst = 1'b0;
  endtask

  function automatic logic pbit(logic [19:0] pat, int per, int idx);
    return pat[per - 1 - (idx % per)];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(2'd0);
    chk("R1 locked after reset", int'(locked), 0);
    chk("R1 rep after reset", int'(rep_count), 0);
    chk("R1 err after reset", int'(err_pulse), 0);
    chk("R1 ready", int'(in_ready), 1);

    // Table walk: every accepted period at various rotations
    for (int v = 0; v < NV; v++) begin
      string req;
      int per, off;
      per = V_PER[v]; off = V_OFF[v];
      req = (V_PROTO[v] == 2'd0) ? "R2" : (V_PROTO[v] == 2'd1) ? "R3" : "R4";
      do_reset(V_PROTO[v]);
      for (int i = 0; i < per * THR; i++) begin
        send(pbit(V_PAT[v], per, i + off));
        if (i == per - 2) chk({req, " R5 rep before first period"}, int'(rep_count), 0);
        if (i == per - 1) chk({req, " R5 rep after first period"}, int'(rep_count), 1);
        if (i == per * (THR - 1) - 1) chk({req, " not yet locked"}, int'(locked), 0);
      end
      chk({req, " locked at threshold"}, int'(locked), 1);
      chk({req, " rep at threshold"}, int'(rep_count), THR);
      for (int i = 0; i < per; i++) send(pbit(V_PAT[v], per, per * THR + i + off));
      chk({req, " R10 lock held"}, int'(locked), 1);
      chk({req, " R5 rep keeps counting"}, int'(rep_count), THR + 1);
    end

    // R6: constant and wrong-pattern streams
    do_reset(2'd2);
    for (int i = 0; i < 200; i++) send(1'b0);
    chk("R6 zeros rep", int'(rep_count), 0);
    do_reset(2'd0);
    for (int i = 0; i < 200; i++) send(1'b1);
    chk("R6 ones rep", int'(rep_count), 0);
    do_reset(2'd1);
    for (int i = 0; i < 200; i++) send(logic'(i % 2));
    chk("R6 alternating in nibble mode", int'(rep_count), 0);
    chk("R6 no lock", int'(locked), 0);

    // R4: code 3 never locks
    do_reset(2'd3);
    for (int i = 0; i < 300; i++) send(logic'(i % 2));
    chk("R4 code 3 rep", int'(rep_count), 0);

    // R7: corruption after lock in code 1, then R8 gap, then R9
    do_reset(2'd1);
    for (int i = 0; i < 8 * THR; i++) send(pbit(20'h0000F, 8, i));
    chk("R7 locked before fault", int'(locked), 1);
    send(~pbit(20'h0000F, 8, 8 * THR));
    chk("R7 err pulse", int'(err_pulse), 1);
    chk("R7 lock dropped", int'(locked), 0);
    chk("R7 rep cleared", int'(rep_count), 0);
    for (int i = 1; i <= 8; i++) begin
      send(pbit(20'h0000F, 8, 8 * THR + i));
      if (i == 1) chk("R7 err one cycle", int'(err_pulse), 0);
      if (i == 7) chk("R7 fresh period needed", int'(rep_count), 0);
      if (i == 8) chk("R7 research finds period", int'(rep_count), 1);
    end
    for (int i = 9; i <= 20; i++) send(pbit(20'h0000F, 8, 8 * THR + i));
    chk("R8 rep before gap", int'(rep_count), 2);
    idle(10);
    chk("R8 rep held during gap", int'(rep_count), 2);
    chk("R8 no err in gap", int'(err_pulse), 0);
    for (int i = 21; i <= 24; i++) send(pbit(20'h0000F, 8, 8 * THR + i));
    chk("R8 rep continues after gap", int'(rep_count), 3);

    // R9: protocol change clears on next clock
    proto_sel = 2'd2;
    idle(1);
    chk("R9 rep cleared", int'(rep_count), 0);
    chk("R9 lock cleared", int'(locked), 0);

    // R7: mismatch before lock in code 0
    do_reset(2'd0);
    for (int i = 0; i < 30; i++) send(pbit(20'h003FF, 20, i));
    chk("R7 rep before fault code 0", int'(rep_count), 1);
    send(~pbit(20'h003FF, 20, 30));
    chk("R7 err pulse code 0", int'(err_pulse), 1);
    chk("R7 rep cleared code 0", int'(rep_count), 0);

    report();
    $finish;
  end

endmodule